// File: doc/BRIEF.md
# Jump Resolution Unit

This block settles the outcome of a jump-class instruction once it has been decoded. It receives a 4-bit condition code, the four arithmetic flags, the address of the next sequential instruction, a mode bit and the operand values. One clock later it reports three things: whether the jump is taken, the address execution continues from, and, for a call, a write request that saves the return address.

Two target modes are supported. Register mode gives an absolute target: a source register value plus a sign-extended displacement. Immediate mode gives a target relative to the next sequential instruction address. The condition code sits in the instruction field that normally holds a destination register number. Code 1 means "call", which always branches and also asks for the return-pointer register to be written.

Top module: `jump_resolver`

## Requirements
- R1: While reset is held low and in the first cycle after it, `out_valid`, `taken` and `link_we` are 0, and `next_ip` and `link_data` are 0.
- R2: Condition code 0 (unconditional) and code 1 (call) are taken whatever the flags are. Flag bit order is carry=bit0, zero=bit1, sign=bit2, overflow=bit3.
- R3: Codes 2/3 test carry, 4/5 test zero, 6/7 test sign and 8/9 test overflow. The even code of each pair is taken when its flag is 1, and the odd code is taken when its flag is 0.
- R4: Code 10 is taken when carry and zero are both 0. Code 11 is taken when either of them is 1.
- R5: Code 12 is taken when sign differs from overflow. Code 13 is taken when they are equal.
- R6: Code 14 is taken when zero is 0 and sign equals overflow. Code 15 is taken in every other case.
- R7: When `use_reg` is 1, a taken jump's `next_ip` is `src_val` plus the sign-extended `disp`, modulo 2^32.
- R8: When `use_reg` is 0, a taken jump's `next_ip` is `ip_next` plus the sign-extended `disp`, modulo 2^32.
- R9: When the condition is false, `next_ip` equals `ip_next` and `link_we` is 0.
- R10: A call asserts `link_we` with `link_idx` = 14 and `link_data` = the sampled `ip_next`. No other code asserts `link_we`.
- R11: Results appear in the cycle after `in_valid` is sampled high, together with `out_valid` = 1. After a cycle with `in_valid` low, `out_valid`, `taken` and `link_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A jump-class instruction is presented |
| cond | input | 4 | Condition code from the destination field |
| flags | input | 4 | {overflow, sign, zero, carry} |
| ip_next | input | 32 | Address of the next sequential instruction |
| use_reg | input | 1 | 1 = register-based target, 0 = relative target |
| src_val | input | 32 | Source register value |
| disp | input | 16 | Displacement, sign-extended inside the block |
| out_valid | output | 1 | Result registers hold a fresh decision |
| taken | output | 1 | The jump is taken |
| next_ip | output | 32 | Address to continue from |
| link_we | output | 1 | Write request for the return-pointer register |
| link_idx | output | 4 | Register number to write (14) |
| link_data | output | 32 | Return address to write |

## Verification
The hardest cases to reach are the compound conditions: greater and not-greater, and less and not-less. They only split apart when sign and overflow disagree, and zero must be set or clear at the same time. Directed stimulus alone would rarely produce those mixes. The bench therefore sweeps all sixteen flag patterns against every condition code, and checks both the taken bit and the fall-through address each time. Wrap-around targets are forced with a negative displacement on a zero base and a large positive displacement on a base near the top of the address space.

// File: rtl/jres_pkg.sv
package jres_pkg;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zero;
    logic carry;
  } flags_t;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'd0,  C_CALL  = 4'd1,
    C_CARRY  = 4'd2,  C_NCARRY = 4'd3,
    C_ZERO   = 4'd4,  C_NZERO = 4'd5,
    C_SIGN   = 4'd6,  C_NSIGN = 4'd7,
    C_OVF    = 4'd8,  C_NOVF  = 4'd9,
    C_ABOVE  = 4'd10, C_NABOVE = 4'd11,
    C_LESS   = 4'd12, C_NLESS = 4'd13,
    C_GREAT  = 4'd14, C_NGREAT = 4'd15
  } cond_e;

  // Each even/odd code pair shares one base test; the low bit inverts it.
  // Pair 0 (always, call) has no inversion.
  function automatic logic pair_base(input logic [2:0] pair, input flags_t f);
    logic b;
    case (pair)
      3'd0: b = 1'b1;
      3'd1: b = f.carry;
      3'd2: b = f.zero;
      3'd3: b = f.sgn;
      3'd4: b = f.ovf;
      3'd5: b = !f.carry && !f.zero;
      3'd6: b = f.sgn ^ f.ovf;
      default: b = !f.zero && (f.sgn == f.ovf);
    endcase
    return b;
  endfunction

  function automatic logic cond_met(input logic [3:0] code, input flags_t f);
    logic inv;
    inv = code[0] && (code[3:1] != 3'd0);
    return pair_base(code[3:1], f) ^ inv;
  endfunction

  function automatic logic [31:0] sext32(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

endpackage

// File: rtl/jres_cond_eval.sv
module jres_cond_eval
  import jres_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     flags,
  output logic       hit,
  output logic       is_call
);
  assign hit     = cond_met(cond, flags);
  assign is_call = (cond == C_CALL);
endmodule

// File: rtl/jres_target.sv
module jres_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              use_reg,
  input  logic [ADDR_W-1:0] src_val,
  input  logic [ADDR_W-1:0] ip_next,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] base;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_x = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_noext
      assign disp_x = disp[ADDR_W-1:0];
    end
  endgenerate

  assign base   = use_reg ? src_val : ip_next;
  assign target = base + disp_x;
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jres_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 16,
  parameter int REG_W    = 4,
  parameter int LINK_REG = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        cond,
  input  logic [3:0]        flags,
  input  logic [ADDR_W-1:0] ip_next,
  input  logic              use_reg,
  input  logic [ADDR_W-1:0] src_val,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] next_ip,
  output logic              link_we,
  output logic [REG_W-1:0]  link_idx,
  output logic [ADDR_W-1:0] link_data
);
  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  flags_t            flg;
  logic              cond_hit;
  logic              call_req;
  logic [ADDR_W-1:0] jump_tgt;

  assign flg = flags;

  jres_cond_eval u_cond (
    .cond    (cond),
    .flags   (flg),
    .hit     (cond_hit),
    .is_call (call_req)
  );

  jres_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .use_reg (use_reg),
    .src_val (src_val),
    .ip_next (ip_next),
    .disp    (disp),
    .target  (jump_tgt)
  );

  assign link_idx = LINK_IDX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      next_ip   <= '0;
      link_data <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && cond_hit;
      link_we   <= in_valid && call_req;
      if (in_valid) begin
        next_ip   <= cond_hit ? jump_tgt : ip_next;
        link_data <= ip_next;
      end
    end
  end

  // R2
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (cond[3:1] == 3'd0) |=> taken);

  // R4
  above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond == 4'd10 && !flags[0] && !flags[1] |=> taken);

  // R6
  greater_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond == 4'd14 && flags[1] |=> !taken);

  // R9
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !taken |-> next_ip == $past(ip_next) && !link_we);

  // R8
  rel_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond == 4'd0 && !use_reg
    |=> next_ip == $past(ip_next) + ADDR_W'($signed(disp)));

  // R10
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond == 4'd1 |=> link_we && taken && link_data == $past(ip_next));

  // R10
  link_only_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond != 4'd1 |=> !link_we);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !taken && !link_we);

endmodule

// File: tb/jump_resolver_bench.sv
module jump_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  cond = '0;
  logic [3:0]  flags = '0;
  logic [31:0] ip_next = '0;
  logic        use_reg = 1'b0;
  logic [31:0] src_val = '0;
  logic [15:0] disp = '0;
  logic        out_valid, taken, link_we;
  logic [31:0] next_ip, link_data;
  logic [3:0]  link_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  jump_resolver u_jump_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond), .flags(flags),
    .ip_next(ip_next), .use_reg(use_reg), .src_val(src_val), .disp(disp),
    .out_valid(out_valid), .taken(taken), .next_ip(next_ip), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference decision written per code from the requirement text.
  function automatic bit ref_taken(input logic [3:0] c, input logic [3:0] f);
    bit cy, z, s, o;
    cy = f[0]; z = f[1]; s = f[2]; o = f[3];
    case (c)
      0, 1: return 1;
      2: return cy;   3: return !cy;
      4: return z;    5: return !z;
      6: return s;    7: return !s;
      8: return o;    9: return !o;
      10: return (cy == 0) && (z == 0);
      11: return cy || z;
      12: return s != o;
      13: return s == o;
      14: return (z == 0) && (s == o);
      default: return z || (s != o);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c < 2) return "R2";
    if (c < 10) return "R3";
    if (c < 12) return "R4";
    if (c < 14) return "R5";
    return "R6";
  endfunction

  // Present one instruction and wait until its result is registered.
  task automatic issue(input logic [3:0] c, input logic [3:0] f, input logic ur,
                       input logic [31:0] src, input logic [31:0] ip, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; cond = c; flags = f; use_reg = ur;
    src_val = src; ip_next = ip; disp = d;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "out_valid in reset", 32'(out_valid), 0);
    chk("R1", "next_ip in reset", next_ip, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "taken after reset", 32'(taken), 0);
    chk("R1", "link_we after reset", 32'(link_we), 0);
    chk("R1", "link_data after reset", link_data, 0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] ip;
        bit exp_t;
        ip = 32'h0000_4000 + 32'(c * 64 + f * 4);
        exp_t = ref_taken(4'(c), 4'(f));
        issue(4'(c), 4'(f), 1'b0, 32'h0, ip, 16'h0020);
        chk(req_of(4'(c)), "taken", 32'(taken), 32'(exp_t));
        chk("R11", "out_valid", 32'(out_valid), 1);
        if (exp_t) chk("R8", "relative target", next_ip, ip + 32'h20);
        else begin
          chk("R9", "fall-through ip", next_ip, ip);
          chk("R9", "no link write", 32'(link_we), 0);
        end
      end
    end
  endtask

  task automatic t_call();
    issue(4'd1, 4'b0000, 1'b0, 32'h0, 32'h0000_1000, 16'hFFF8);
    chk("R10", "link_we", 32'(link_we), 1);
    chk("R10", "link_idx", 32'(link_idx), 14);
    chk("R10", "link_data", link_data, 32'h0000_1000);
    chk("R8", "call target", next_ip, 32'h0000_0FF8);
    issue(4'd1, 4'b1111, 1'b1, 32'h8000_0000, 32'h0000_2222, 16'h0010);
    chk("R10", "reg call link_data", link_data, 32'h0000_2222);
    chk("R7", "reg call target", next_ip, 32'h8000_0010);
    issue(4'd0, 4'b0000, 1'b1, 32'h1234_0000, 32'h0000_0100, 16'h0004);
    chk("R10", "jmp no link", 32'(link_we), 0);
  endtask

  task automatic t_reg_mode();
    issue(4'd0, 4'b0000, 1'b1, 32'h0000_0000, 32'h0000_5000, 16'hFFFF);
    chk("R7", "wrap below zero", next_ip, 32'hFFFF_FFFF);
    issue(4'd0, 4'b0000, 1'b1, 32'hFFFF_FFF0, 32'h0000_5000, 16'h7FFF);
    chk("R7", "wrap above top", next_ip, 32'h0000_7FEF);
    issue(4'd4, 4'b0010, 1'b1, 32'h0001_0000, 32'h0000_5000, 16'h8000);
    chk("R7", "conditional reg target", next_ip, 32'h0000_8000);
    issue(4'd0, 4'b0000, 1'b0, 32'h0001_0000, 32'h0000_0010, 16'hFFE0);
    chk("R8", "relative wrap", next_ip, 32'hFFFF_FFF0);
  endtask

  task automatic t_idle();
    issue(4'd1, 4'b0000, 1'b0, 32'h0, 32'h0000_0040, 16'h0);
    @(posedge clk); #1;
    chk("R11", "out_valid idle", 32'(out_valid), 0);
    chk("R11", "taken idle", 32'(taken), 0);
    chk("R11", "link_we idle", 32'(link_we), 0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_call();
    t_reg_mode();
    t_idle();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule